// File: doc/BRIEF.md
# Translation Protection Fault Checker

This block sits after the translation lookup of a memory pipeline. It takes the attributes of one memory reference together with the page entry found for it. It then decides whether the reference may go ahead or which single fault it must raise. The reference is described by its kind (fetch, load or store), a flag for the legacy 32-bit address mode, and its virtual address. The page entry supplies its access bit, its dirty bit and its 24-bit protection key.

Permission is not held in the page entry. It comes from a bank of protection key slots, searched associatively whenever a status enable is set. Each slot carries a valid flag, a key and three disable flags, one each for read, write and execute. A write port loads one slot per cycle. The block only inspects the access and dirty bits and never changes them. Software keeps those bits up to date and services the traps. The verdict appears one cycle after the request as a one-hot fault vector and a grant.

Top module: `prot_fault_check`

## Requirements
- R1: After reset, rsp_valid, rsp_grant and rsp_fault are all zero, and every key slot is invalid, so with key_en=1 any key raises a key miss.
- R2: Each request with req_valid=1 is answered exactly one clock later with rsp_valid=1. A cycle with req_valid=0 gives rsp_valid=0, rsp_grant=0 and rsp_fault=0 one clock later.
- R3: A legacy-mode reference (req_legacy=1) with any address bit at or above bit 32 set raises the range fault, rsp_fault=5'b00001. A native reference (req_legacy=0) is never range checked.
- R4: With key_en=0 the key slots are not consulted, and neither the key miss bit nor the key permission bit is raised.
- R5: With key_en=1 and no valid slot whose key equals pg_key, the key miss fault rsp_fault=5'b00010 is raised.
- R6: With key_en=1 and a matching slot, the key permission fault rsp_fault=5'b00100 is raised when the slot's disable flag for the kind is set. The kind codes are 2'b00 fetch (execute flag), 2'b01 load (read flag), 2'b10 store (write flag) and 2'b11 treated as a load. If several slots match, the lowest-numbered one decides.
- R7: A reference to a page with pg_acc=0 raises the access fault rsp_fault=5'b01000, in both native and legacy mode.
- R8: A store (kind 2'b10) to a page with pg_dirty=0 raises the dirty fault rsp_fault=5'b10000. Fetches and loads ignore pg_dirty.
- R9: rsp_fault has at most one bit set. When several faults apply, the one reported is chosen in this order: range, key miss, key permission, access, dirty.
- R10: rsp_grant is 1 exactly when rsp_valid=1 and rsp_fault is zero.
- R11: A slot write (kw_en=1) takes effect at the clock edge on which it is sampled. A request sampled on that same edge still sees the old slot contents. A write with kw_valid=0 removes the slot from the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 load |
| req_legacy | input | 1 | Reference made in legacy 32-bit address mode |
| req_vaddr | input | 64 | Virtual address of the reference |
| pg_acc | input | 1 | Page access bit |
| pg_dirty | input | 1 | Page dirty bit |
| pg_key | input | 24 | Page protection key |
| key_en | input | 1 | Status enable for the key search |
| kw_en | input | 1 | Write one key slot |
| kw_idx | input | 4 | Slot number to write |
| kw_valid | input | 1 | Valid flag written to the slot |
| kw_key | input | 24 | Key written to the slot |
| kw_rd_dis | input | 1 | Read disable written to the slot |
| kw_wr_dis | input | 1 | Write disable written to the slot |
| kw_ex_dis | input | 1 | Execute disable written to the slot |
| rsp_valid | output | 1 | Verdict present |
| rsp_grant | output | 1 | Reference may proceed |
| rsp_fault | output | 5 | One-hot fault: bit0 range, bit1 key miss, bit2 key permission, bit3 access, bit4 dirty |

## Verification
The properties assume that req_kind, req_legacy, req_vaddr and the page attributes are stable and known on every edge where req_valid is high. They also assume reset is applied before the first request. The bench changes inputs only on falling edges and holds each request for exactly one rising edge. It uses only the four defined kind codes, the fourth of which is checked to act as a load. Slot writes are issued either alone or deliberately on the same edge as a request, which exercises the old-contents rule.

// File: rtl/prot_fault_check.sv
module prot_fault_check #(
  parameter int NUM_KEYS = 16,
  parameter int KEY_W    = 24,
  parameter int VA_W     = 64,
  parameter int LEGACY_W = 32,
  localparam int IDX_W   = $clog2(NUM_KEYS),
  localparam int NF      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             req_legacy,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             pg_acc,
  input  logic             pg_dirty,
  input  logic [KEY_W-1:0] pg_key,
  input  logic             key_en,
  input  logic             kw_en,
  input  logic [IDX_W-1:0] kw_idx,
  input  logic             kw_valid,
  input  logic [KEY_W-1:0] kw_key,
  input  logic             kw_rd_dis,
  input  logic             kw_wr_dis,
  input  logic             kw_ex_dis,
  output logic             rsp_valid,
  output logic             rsp_grant,
  output logic [NF-1:0]    rsp_fault
);

  logic [NUM_KEYS-1:0] slot_v, slot_rd, slot_wr, slot_ex, hit;
  logic [KEY_W-1:0]    slot_key [NUM_KEYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v  <= '0;
      slot_rd <= '0;
      slot_wr <= '0;
      slot_ex <= '0;
      for (int i = 0; i < NUM_KEYS; i++) slot_key[i] <= '0;
    end else if (kw_en) begin
      slot_v[kw_idx]   <= kw_valid;
      slot_rd[kw_idx]  <= kw_rd_dis;
      slot_wr[kw_idx]  <= kw_wr_dis;
      slot_ex[kw_idx]  <= kw_ex_dis;
      slot_key[kw_idx] <= kw_key;
    end
  end

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_match
    assign hit[g] = slot_v[g] && (slot_key[g] == pg_key);
  end

  logic sel_rd, sel_wr, sel_ex;
  always_comb begin
    sel_rd = 1'b0;
    sel_wr = 1'b0;
    sel_ex = 1'b0;
    for (int i = NUM_KEYS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_rd = slot_rd[i];
        sel_wr = slot_wr[i];
        sel_ex = slot_ex[i];
      end
    end
  end

  wire is_fetch = (req_kind == 2'b00);
  wire is_store = (req_kind == 2'b10);
  wire perm_bad = is_fetch ? sel_ex : (is_store ? sel_wr : sel_rd);

  wire f_range = req_legacy && (|req_vaddr[VA_W-1:LEGACY_W]);
  wire f_miss  = key_en && !(|hit);
  wire f_perm  = key_en && (|hit) && perm_bad;
  wire f_acc   = !pg_acc;
  wire f_dirty = is_store && !pg_dirty;

  logic [NF-1:0] fault_n;
  always_comb begin
    fault_n = '0;
    if (f_range)      fault_n[0] = 1'b1;
    else if (f_miss)  fault_n[1] = 1'b1;
    else if (f_perm)  fault_n[2] = 1'b1;
    else if (f_acc)   fault_n[3] = 1'b1;
    else if (f_dirty) fault_n[4] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_fault <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= req_valid && (fault_n == '0);
      rsp_fault <= req_valid ? fault_n : '0;
    end
  end

endmodule

// File: rtl/prot_fault_check_chk.sv
module prot_fault_check_chk #(
  parameter int VA_W     = 64,
  parameter int LEGACY_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_kind,
  input logic            req_legacy,
  input logic [VA_W-1:0] req_vaddr,
  input logic            pg_acc,
  input logic            pg_dirty,
  input logic            key_en,
  input logic            rsp_valid,
  input logic            rsp_grant,
  input logic [4:0]      rsp_fault
);

  // R2
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_grant && rsp_fault == 5'b0));

  // R9
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_fault));

  // R10
  grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_grant == (rsp_fault == 5'b0)));

  // R3
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_legacy && (|req_vaddr[VA_W-1:LEGACY_W])) |=> (rsp_fault == 5'b00001));

  // R4
  nokey_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !key_en) |=> (!rsp_fault[1] && !rsp_fault[2]));

  // R7
  acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pg_acc) |=> (!rsp_grant && !rsp_fault[4]));

  // R8
  dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b10 && !pg_dirty) |=> !rsp_grant);

endmodule

bind prot_fault_check prot_fault_check_chk #(.VA_W(VA_W), .LEGACY_W(LEGACY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_legacy(req_legacy), .req_vaddr(req_vaddr), .pg_acc(pg_acc),
  .pg_dirty(pg_dirty), .key_en(key_en), .rsp_valid(rsp_valid),
  .rsp_grant(rsp_grant), .rsp_fault(rsp_fault)
);

// File: tb/test_prot_fault_check.sv
module test_prot_fault_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b01;
  logic        req_legacy = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic        pg_acc = 1'b1, pg_dirty = 1'b1;
  logic [23:0] pg_key = '0;
  logic        key_en = 1'b0;
  logic        kw_en = 1'b0;
  logic [3:0]  kw_idx = '0;
  logic        kw_valid = 1'b0;
  logic [23:0] kw_key = '0;
  logic        kw_rd_dis = 1'b0, kw_wr_dis = 1'b0, kw_ex_dis = 1'b0;
  logic        rsp_valid, rsp_grant;
  logic [4:0]  rsp_fault;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prot_fault_check i_prot_fault_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_legacy(req_legacy), .req_vaddr(req_vaddr), .pg_acc(pg_acc),
    .pg_dirty(pg_dirty), .pg_key(pg_key), .key_en(key_en), .kw_en(kw_en),
    .kw_idx(kw_idx), .kw_valid(kw_valid), .kw_key(kw_key),
    .kw_rd_dis(kw_rd_dis), .kw_wr_dis(kw_wr_dis), .kw_ex_dis(kw_ex_dis),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault)
  );

  localparam logic [1:0] FE = 2'b00, LD = 2'b01, ST = 2'b10, XX = 2'b11;

  function automatic logic [35:0] mk(logic [1:0] k, logic lg, logic hi, logic a,
                                     logic d, logic [23:0] key, logic ken, logic [4:0] ef);
    return {k, lg, hi, a, d, key, ken, ef};
  endfunction

  localparam int NV = 23;
  localparam logic [35:0] VEC [NV] = '{
    mk(LD,0,0,1,1,24'h111,1,5'b00000),  // R10 grant
    mk(ST,0,0,1,1,24'h111,1,5'b00000),  // R10
    mk(FE,0,0,1,1,24'h111,1,5'b00000),  // R10
    mk(LD,0,0,1,1,24'h222,1,5'b00100),  // R6 read disabled
    mk(FE,0,0,1,1,24'h222,1,5'b00000),  // R6
    mk(ST,0,0,1,1,24'h333,1,5'b00100),  // R6 write disabled
    mk(LD,0,0,1,1,24'h333,1,5'b00000),  // R6
    mk(FE,0,0,1,1,24'h444,1,5'b00100),  // R6 exec disabled
    mk(ST,0,0,1,1,24'h444,1,5'b00000),  // R6
    mk(LD,0,0,1,1,24'h999,1,5'b00010),  // R5 miss
    mk(LD,0,0,1,1,24'h999,0,5'b00000),  // R4 no search
    mk(LD,0,0,1,1,24'h555,1,5'b00010),  // R5 invalid slot
    mk(LD,0,0,0,1,24'h111,1,5'b01000),  // R7
    mk(ST,0,0,1,0,24'h111,1,5'b10000),  // R8
    mk(LD,0,0,1,0,24'h111,1,5'b00000),  // R8 load ignores dirty
    mk(LD,1,1,1,1,24'h111,1,5'b00001),  // R3 legacy range
    mk(LD,0,1,1,1,24'h111,1,5'b00000),  // R3 native no range
    mk(LD,1,1,0,1,24'h999,1,5'b00001),  // R9 range wins
    mk(ST,0,0,0,0,24'h999,1,5'b00010),  // R9 miss wins
    mk(ST,0,0,0,0,24'h333,1,5'b00100),  // R9 perm wins
    mk(XX,0,0,1,1,24'h222,1,5'b00100),  // R6 code 11 acts as load
    mk(ST,0,0,0,0,24'h111,0,5'b01000),  // R9 access over dirty, R4
    mk(LD,1,0,0,1,24'h111,1,5'b01000)   // R7 legacy access
  };

  task automatic chk(string req, logic [4:0] ef, logic ev, logic eg);
    n_run++;
    if (rsp_fault !== ef || rsp_valid !== ev || rsp_grant !== eg) begin
      n_fail++;
      $display("FAIL %s: got valid=%b grant=%b fault=%b, expected valid=%b grant=%b fault=%b",
               req, rsp_valid, rsp_grant, rsp_fault, ev, eg, ef);
    end
  endtask

  task automatic wr_slot(logic [3:0] idx, logic v, logic [23:0] key, logic rd, logic wr, logic ex);
    @(negedge clk);
    kw_en = 1'b1; kw_idx = idx; kw_valid = v; kw_key = key;
    kw_rd_dis = rd; kw_wr_dis = wr; kw_ex_dis = ex;
    @(negedge clk);
    kw_en = 1'b0;
  endtask

  task automatic do_req(string req, logic [1:0] k, logic lg, logic hi, logic a, logic d,
                        logic [23:0] key, logic ken, logic [4:0] ef);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_legacy = lg;
    req_vaddr = hi ? 64'h0000_0001_0000_0000 : 64'h0000_0000_FFFF_F000;
    pg_acc = a; pg_dirty = d; pg_key = key; key_en = ken;
    @(negedge clk);
    req_valid = 1'b0;
    kw_en = 1'b0;
    chk(req, ef, 1'b1, ef == 5'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", 5'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    do_req("R1 empty slots miss", LD, 0, 0, 1, 1, 24'h111, 1, 5'b00010);
    @(negedge clk);
    chk("R2 idle cycle", 5'b0, 1'b0, 1'b0);

    wr_slot(4'd0, 1, 24'h111, 0, 0, 0);
    wr_slot(4'd1, 1, 24'h222, 1, 0, 0);
    wr_slot(4'd2, 1, 24'h333, 0, 1, 0);
    wr_slot(4'd3, 1, 24'h444, 0, 0, 1);
    wr_slot(4'd5, 0, 24'h555, 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      do_req($sformatf("vector %0d (R3..R10)", i), v[35:34], v[33], v[32], v[31], v[30],
             v[29:6], v[5], v[4:0]);
    end

    // R11: write on the same edge as a request is not seen by it
    @(negedge clk);
    kw_en = 1'b1; kw_idx = 4'd6; kw_valid = 1'b1; kw_key = 24'h777;
    kw_rd_dis = 1'b0; kw_wr_dis = 1'b0; kw_ex_dis = 1'b0;
    req_valid = 1'b1; req_kind = LD; req_legacy = 1'b0; req_vaddr = '0;
    pg_acc = 1'b1; pg_dirty = 1'b1; pg_key = 24'h777; key_en = 1'b1;
    @(negedge clk);
    kw_en = 1'b0; req_valid = 1'b0;
    chk("R11 same-edge write unseen", 5'b00010, 1'b1, 1'b0);
    do_req("R11 write visible next", LD, 0, 0, 1, 1, 24'h777, 1, 5'b00000);
    wr_slot(4'd6, 0, 24'h777, 0, 0, 0);
    do_req("R11 invalidated slot", LD, 0, 0, 1, 1, 24'h777, 1, 5'b00010);

    // R6: lowest-numbered matching slot decides
    wr_slot(4'd7, 1, 24'h888, 0, 0, 1);
    wr_slot(4'd8, 1, 24'h888, 0, 0, 0);
    do_req("R6 lowest match decides", FE, 0, 0, 1, 1, 24'h888, 1, 5'b00100);
    wr_slot(4'd15, 1, 24'hABC, 0, 0, 0);
    do_req("R11 top slot index", ST, 0, 0, 1, 1, 24'hABC, 1, 5'b00000);

    // R1: reset clears slots
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", 5'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    do_req("R1 slots cleared", LD, 0, 0, 1, 1, 24'h111, 1, 5'b00010);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule